// File: doc/BRIEF.md
# Pre-Trigger Sample Capture Engine

The block records a continuous stream of receiver samples into a circular history buffer and, on request, replays a window of that history as a framed record. Every accepted sample is packed into one 64-bit word that carries the in-phase and quadrature values, the front-end gain word (a lock flag plus a 7-bit gain) and a half-dB signal strength reading. Writing never pauses for a trigger, so the buffer always holds the most recent past.

When a trigger pulse arrives while the block is idle, it takes a snapshot of a free-running 64-bit timer and begins a record. The record's first word is that snapshot. It is followed by a programmable number of sample words. The window is shifted back into history by a separately programmable look-back depth. The record leaves through a valid/ready stream with a last flag. Samples that arrive after the trigger keep landing in the buffer while the record drains, and they become part of the record as they come in.

Top module: `pretrig_capture`

## Requirements
- R1: Each stored word is laid out as bits 15:0 in-phase, bits 31:16 quadrature, bit 39 lock flag, bits 38:32 gain, bits 47:40 zero, and bits 63:48 signal strength.
- R2: Every cycle with the sample strobe high stores exactly one word, in arrival order, including cycles in which a record is being emitted.
- R3: A trigger seen while idle captures the timer input of that same cycle, and the first record word is that captured value.
- R4: After the timestamp the record carries exactly `cfg_rec_len` sample words (a value of 0 is treated as 1), and the last flag is high on the final sample word only.
- R5: The first sample word of a record is the sample that arrived `cfg_pre_len` accepted samples before the trigger cycle. A sample accepted in the trigger cycle itself is the one at offset `cfg_pre_len` in the record.
- R6: The look-back depth actually used is the smallest of `cfg_pre_len`, the number of samples accepted since reset, and the buffer depth minus one.
- R7: A trigger that arrives while a record is still pending or being emitted has no effect. It causes no extra record and does not alter the timestamp.
- R8: While `rec_valid` is high and `rec_ready` low, the data and last flag hold steady. `rec_valid` is low while idle, and low while the next record sample has not yet arrived.
- R9: While a record is in progress, an incoming sample that would overwrite a record word not yet emitted is discarded. Record words are never corrupted.
- R10: The record length and the look-back depth are independent. A record shorter than its look-back depth ends before reaching the trigger point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | 16 | In-phase value |
| smp_q | input | 16 | Quadrature value |
| smp_lock | input | 1 | Front-end gain lock flag |
| smp_gain | input | 7 | Front-end gain value |
| smp_rssi | input | 16 | Signal strength, half-dB units |
| trig | input | 1 | Trigger pulse |
| timer | input | 64 | Free-running time base |
| cfg_pre_len | input | LEN_W | Look-back depth in samples |
| cfg_rec_len | input | LEN_W | Sample words per record |
| rec_valid | output | 1 | Record word available |
| rec_ready | input | 1 | Downstream accepts word |
| rec_data | output | 64 | Record word (timestamp or sample) |
| rec_last | output | 1 | Final word of record |

## Verification
Assertions check every cycle that a stalled output word holds still, that the write pointer never runs more than one buffer depth ahead of the read pointer, and that the write pointer freezes when the guard against overwriting is active. They also check that the history count stays within its limit, that an idle trigger raises the output valid on the next cycle, and that a trigger during a record leaves the timestamp unchanged. Only the bench scenarios can show that the right samples come out. They cover the look-back offset and its clamping, the word packing, record length and last placement, and the exact set of samples discarded during a long stall. In each case the output is compared against a model of every accepted sample.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int SMP_W = 64;

  typedef struct packed {
    logic [15:0] rssi;
    logic [7:0]  pad;
    logic        lock;
    logic [6:0]  gain;
    logic [15:0] q;
    logic [15:0] i;
  } smp_word_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STAMP = 2'd1,
    SEQ_BODY  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/smp_pack.sv
module smp_pack
  import cap_pkg::*;
(
  input  logic [15:0]      i_val,
  input  logic [15:0]      q_val,
  input  logic             lock,
  input  logic [6:0]       gain,
  input  logic [15:0]      rssi,
  output logic [SMP_W-1:0] word
);
  smp_word_t w;

  always_comb begin
    w.i    = i_val;
    w.q    = q_val;
    w.gain = gain;
    w.lock = lock;
    w.pad  = '0;
    w.rssi = rssi;
    word   = w;
  end
endmodule

// File: rtl/cap_ring.sv
module cap_ring
  import cap_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PW    = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [SMP_W-1:0] wr_word,
  input  logic             hold,
  input  logic [PW-1:0]    rd_ptr,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    fill,
  output logic [SMP_W-1:0] rd_word
);
  localparam logic [PW-1:0] FULL_SPAN = PW'(DEPTH);
  localparam logic [PW-1:0] FILL_MAX  = PW'(DEPTH - 1);

  logic [SMP_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d;
  logic [PW-1:0]    fill_q, fill_d;
  logic [PW-1:0]    span;
  logic             guard;
  logic             wr_en;

  always_comb begin
    span   = wr_q - rd_ptr;
    guard  = hold && (span == FULL_SPAN);
    wr_en  = wr_req && !guard;
    wr_d   = wr_q;
    fill_d = fill_q;
    if (wr_en) begin
      wr_d = wr_q + 1'b1;
      if (fill_q != FILL_MAX) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q[ADDR_W-1:0]] <= wr_word;
  end

  assign wr_ptr  = wr_q;
  assign fill    = fill_q;
  assign rd_word = mem[rd_ptr[ADDR_W-1:0]];

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ((wr_q - rd_ptr) <= FULL_SPAN));

  // R9
  guard_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && ((wr_q - rd_ptr) == FULL_SPAN)) |=> $stable(wr_q));

  // R6
  fill_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX);
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 14,
  localparam int PW    = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [63:0]      timer,
  input  logic [LEN_W-1:0] pre_len,
  input  logic [LEN_W-1:0] rec_len,
  input  logic [PW-1:0]    wr_ptr,
  input  logic [PW-1:0]    fill,
  input  logic [SMP_W-1:0] rd_word,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_data,
  output logic             out_last,
  output logic [PW-1:0]    rd_ptr,
  output logic             busy
);
  seq_state_t       state_q, state_d;
  logic [63:0]      ts_q, ts_d;
  logic [PW-1:0]    rd_q, rd_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] fill_ext, eff_len;
  logic             take;

  always_comb begin
    fill_ext = LEN_W'(fill);
    eff_len  = (pre_len > fill_ext) ? fill_ext : pre_len;

    out_valid = (state_q == SEQ_STAMP) || ((state_q == SEQ_BODY) && (rd_q != wr_ptr));
    out_data  = (state_q == SEQ_STAMP) ? ts_q : rd_word;
    out_last  = (state_q == SEQ_BODY) && (rem_q == LEN_W'(1)) && (rd_q != wr_ptr);
    take      = out_valid && out_ready;

    state_d = state_q;
    ts_d    = ts_q;
    rd_d    = rd_q;
    rem_d   = rem_q;
    case (state_q)
      SEQ_IDLE: begin
        if (trig) begin
          state_d = SEQ_STAMP;
          ts_d    = timer;
          rd_d    = wr_ptr - PW'(eff_len);
          rem_d   = (rec_len == '0) ? LEN_W'(1) : rec_len;
        end
      end
      SEQ_STAMP: begin
        if (take) state_d = SEQ_BODY;
      end
      SEQ_BODY: begin
        if (take) begin
          rd_d  = rd_q + 1'b1;
          rem_d = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ts_q    <= '0;
      rd_q    <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      ts_q    <= ts_d;
      rd_q    <= rd_d;
      rem_q   <= rem_d;
    end
  end

  assign rd_ptr = rd_q;
  assign busy   = (state_q != SEQ_IDLE);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R3
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig) |=> out_valid);

  // R7
  trig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> $stable(ts_q));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import cap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 14,
  localparam int PW    = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [15:0]      smp_i,
  input  logic [15:0]      smp_q,
  input  logic             smp_lock,
  input  logic [6:0]       smp_gain,
  input  logic [15:0]      smp_rssi,
  input  logic             trig,
  input  logic [63:0]      timer,
  input  logic [LEN_W-1:0] cfg_pre_len,
  input  logic [LEN_W-1:0] cfg_rec_len,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [63:0]      rec_data,
  output logic             rec_last
);
  logic [SMP_W-1:0] in_word;
  logic [SMP_W-1:0] rd_word;
  logic [PW-1:0]    wr_ptr, rd_ptr, fill;
  logic             busy;

  smp_pack u_pack (
    .i_val (smp_i),
    .q_val (smp_q),
    .lock  (smp_lock),
    .gain  (smp_gain),
    .rssi  (smp_rssi),
    .word  (in_word)
  );

  cap_ring #(.ADDR_W(ADDR_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (smp_valid),
    .wr_word (in_word),
    .hold    (busy),
    .rd_ptr  (rd_ptr),
    .wr_ptr  (wr_ptr),
    .fill    (fill),
    .rd_word (rd_word)
  );

  cap_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .timer     (timer),
    .pre_len   (cfg_pre_len),
    .rec_len   (cfg_rec_len),
    .wr_ptr    (wr_ptr),
    .fill      (fill),
    .rd_word   (rd_word),
    .out_ready (rec_ready),
    .out_valid (rec_valid),
    .out_data  (rec_data),
    .out_last  (rec_last),
    .rd_ptr    (rd_ptr),
    .busy      (busy)
  );
endmodule

// File: tb/sim_pretrig_capture.sv
`timescale 1ns/1ps
module sim_pretrig_capture;
  localparam int DEPTH = 256;
  localparam int LEN_W = 14;
  localparam int HSZ   = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0, smp_rssi = '0;
  logic smp_lock = 1'b0;
  logic [6:0] smp_gain = '0;
  logic trig = 1'b0;
  logic [63:0] timer = '0;
  logic [LEN_W-1:0] cfg_pre_len = '0, cfg_rec_len = '0;
  logic rec_valid, rec_ready, rec_last;
  logic [63:0] rec_data;

  always #5 clk = ~clk;

  pretrig_capture #(.ADDR_W(8), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .smp_lock(smp_lock), .smp_gain(smp_gain), .smp_rssi(smp_rssi), .trig(trig),
    .timer(timer), .cfg_pre_len(cfg_pre_len), .cfg_rec_len(cfg_rec_len),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data), .rec_last(rec_last)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] hist [HSZ];
  int wcount = 0, rdpos = 0, remain = 0;
  bit busy_m = 0, stamp_m = 0;
  logic [63:0] ts_exp = '0;
  string tag = "R2";
  int records = 0;
  bit done = 0;

  function automatic logic [63:0] pack(logic [15:0] i, logic [15:0] q, logic l, logic [6:0] g, logic [15:0] r);
    return {r, 8'h00, l, g, q, i};
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic step(bit v, bit t, bit r);
    bit exp_valid, take, acc;
    int eff;
    logic [63:0] w;
    @(negedge clk);
    cyc++;
    rec_ready = r;
    smp_valid = v;
    smp_i = 16'($urandom); smp_q = 16'($urandom); smp_lock = 1'($urandom);
    smp_gain = 7'($urandom); smp_rssi = 16'($urandom);
    trig = t;
    timer = 64'h0A5A_0000_0000_0000 + 64'(cyc);
    #1;
    if (!busy_m) exp_valid = 0;
    else if (stamp_m) exp_valid = 1;
    else exp_valid = (rdpos < wcount);
    chk(rec_valid == exp_valid, (tag == "R7") ? "R7" : "R8", 64'(rec_valid), 64'(exp_valid));
    take = exp_valid && r;
    if (exp_valid && rec_valid) begin
      if (stamp_m) begin
        chk(rec_data == ts_exp, "R3", rec_data, ts_exp);
        chk(rec_last == 1'b0, "R4", 64'(rec_last), 64'd0);
      end else begin
        chk(rec_data == hist[rdpos % HSZ], (tag == "R2") ? "R5" : tag, rec_data, hist[rdpos % HSZ]);
        chk(rec_last == (remain == 1), "R4", 64'(rec_last), 64'(remain == 1));
      end
    end
    w = pack(smp_i, smp_q, smp_lock, smp_gain, smp_rssi);
    acc = v && !(busy_m && (wcount - rdpos) == DEPTH);
    if (t && !busy_m) begin
      eff = imin(int'(cfg_pre_len), imin(wcount, DEPTH - 1));
      rdpos = wcount - eff;
      remain = (cfg_rec_len == 0) ? 1 : int'(cfg_rec_len);
      busy_m = 1; stamp_m = 1; ts_exp = timer;
    end else if (take) begin
      if (stamp_m) stamp_m = 0;
      else begin
        rdpos++; remain--;
        if (remain == 0) begin busy_m = 0; records++; end
      end
    end
    if (acc) begin
      hist[wcount % HSZ] = w;
      wcount++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (busy_m && guard < 5000) begin
      step(1'b0, 1'b0, 1'b1);
      guard++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog cycle %0d actual timeout expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rec_before;
    void'($urandom(32'd1337));
    rec_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rec_valid == 1'b0, "R8", 64'(rec_valid), 64'd0);
    chk(rec_last == 1'b0, "R4", 64'(rec_last), 64'd0);
    rst_n = 1'b1;

    // R6: look-back larger than history since reset
    tag = "R6";
    cfg_pre_len = 10; cfg_rec_len = 5;
    step(1, 0, 1); step(1, 0, 1);
    step(1, 1, 1);
    repeat (8) step(1, 0, 1);
    drain();

    // R1: packing of one known sample
    tag = "R1";
    cfg_pre_len = 0; cfg_rec_len = 1;
    @(negedge clk);
    cyc++;
    rec_ready = 1; smp_valid = 1; trig = 1;
    smp_i = 16'h1111; smp_q = 16'h2222; smp_lock = 1; smp_gain = 7'h55; smp_rssi = 16'h0333;
    @(negedge clk);
    cyc++;
    smp_valid = 0; trig = 0;
    wcount++;
    @(negedge clk);
    cyc++;
    chk(rec_valid && rec_data == 64'h0333_00D5_2222_1111, "R1", rec_data, 64'h0333_00D5_2222_1111);
    chk(rec_last == 1'b1, "R4", 64'(rec_last), 64'd1);
    hist[(wcount - 1) % HSZ] = 64'h0333_00D5_2222_1111;
    busy_m = 0;

    // R5: zero look-back, record made of post-trigger samples
    tag = "R5";
    cfg_pre_len = 0; cfg_rec_len = 4;
    repeat (5) step(1, 0, 1);
    step(1, 1, 1);
    repeat (6) step(($urandom % 2) == 0, 0, 1);
    drain();

    // R10: record shorter than look-back
    tag = "R10";
    cfg_pre_len = 20; cfg_rec_len = 3;
    repeat (25) step(1, 0, 1);
    step(1, 1, 1);
    drain();

    // R4: length zero behaves as one
    tag = "R4";
    cfg_pre_len = 3; cfg_rec_len = 0;
    step(1, 1, 1);
    drain();

    // R6: look-back beyond buffer clamps to depth minus one
    tag = "R6";
    repeat (300) step(1, 0, 1);
    cfg_pre_len = 300; cfg_rec_len = 6;
    step(1, 1, 1);
    drain();

    // R7: triggers while busy are ignored
    tag = "R7";
    rec_before = records;
    cfg_pre_len = 4; cfg_rec_len = 8;
    step(1, 1, 0);
    repeat (6) step(1, 1, 0);
    repeat (4) step(1, 1, 1);
    drain();
    repeat (10) step(1, 0, 1);
    chk(records == rec_before + 1, "R7", 64'(records), 64'(rec_before + 1));

    // R9: long stall, overflowing samples discarded
    tag = "R9";
    cfg_pre_len = 0; cfg_rec_len = 200;
    step(1, 1, 0);
    repeat (400) step(1, 0, 0);
    chk(wcount - rdpos == DEPTH, "R9", 64'(wcount - rdpos), 64'(DEPTH));
    drain();

    // R2: random traffic
    tag = "R2";
    for (int n = 0; n < 30000; n++) begin
      if (!busy_m && ($urandom % 8) == 0) begin
        cfg_pre_len = LEN_W'($urandom % 300);
        cfg_rec_len = LEN_W'($urandom % 300);
      end
      step(($urandom % 4) != 0, ($urandom % 50) == 0, ($urandom % 10) < 7);
    end
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule